// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

The bridge lets a host reach an 8-bit PHY register file through only two 16-bit host registers. One is a command register: it holds the target PHY offset, a write flag and a read-only busy flag. The other is a staging data register. A command write starts one transaction on a request/acknowledge port toward the PHY register file, and that port may answer after any number of cycles. The busy flag stays high until the acknowledge arrives. On a read, the returned byte is then placed in the low bits of the data register.

To write a PHY register, software first loads the data register. It then writes the command register with the offset and the write flag set. To read one, it writes the offset with the write flag clear, polls until busy drops, and takes the low byte of the data register. Host software gives up if busy stays set for about 100 microseconds. The bridge has no timer of its own, so the PHY side must answer within that time.

Top module: `phy_cmd_bridge`

## Requirements
- R1: After reset, busy reads 0, `phy_req` is low, and both host registers read 0x0000.
- R2: A host write to the command register (offset 0x300) while idle sets busy in the next cycle. From then `phy_req` is high, `phy_addr` equals write-data bits 7:0 and `phy_we` equals write-data bit 8.
- R3: In a write transaction, `phy_wdata` carries bits 7:0 of the data register (offset 0x304) as they stood before the command write.
- R4: While busy, `phy_req`, `phy_addr`, `phy_we` and `phy_wdata` hold steady. Busy holds until `phy_ack` is sampled high. In the next cycle busy and `phy_req` are both low. With an answer delay of L cycles in the PHY model, busy stays high for exactly L+2 cycles.
- R5: When a read transaction completes, the data register reads `{8'h00, phy_rdata}`, taking the byte sampled with `phy_ack`.
- R6: A write transaction leaves the data register unchanged.
- R7: Command-register writes while busy are ignored: the offset and flag do not change and no further transaction starts.
- R8: Data-register writes while busy are ignored.
- R9: A read of the command register returns `{6'b0, busy, write flag, offset}`, with busy at bit 9, the write flag at bit 8 and the offset in bits 7:0.
- R10: While idle, a data-register write is read back with all 16 bits intact.
- R11: Host offsets other than 0x300 and 0x304 read 0x0000, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_sel | input | 1 | Host access strobe |
| hst_wr | input | 1 | Host write (1) or read (0) |
| hst_addr | input | 12 | Host byte offset |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, combinational from hst_addr |
| phy_req | output | 1 | Transaction request toward the PHY register file |
| phy_we | output | 1 | Request is a write |
| phy_addr | output | 8 | PHY register offset |
| phy_wdata | output | 8 | PHY write data |
| phy_ack | input | 1 | PHY acknowledge, one cycle |
| phy_rdata | input | 8 | PHY read data, valid with phy_ack |

## Verification
Every one of the 256 PHY offsets is first written with an arithmetic byte pattern and then read back. The PHY answer delay cycles through four values, so the busy length shows whether the flag follows the acknowledge or a fixed count. Because each offset gets a distinct byte, a wrong address, a dropped write or a stale capture shows up at the exact offset where it happens. Separate passes issue command and data writes into a busy window, and touch unmapped offsets. These passes tell apart a bridge that guards its staged state from one that lets a second access through.

// File: rtl/phyb_pkg.sv
package phyb_pkg;
   typedef enum logic {
      XS_IDLE = 1'b0,
      XS_WAIT = 1'b1
   } xact_state_t;
endpackage

// File: rtl/phyb_host_regs.sv
module phyb_host_regs #(
   parameter int          ADDR_W     = 12,
   parameter int          HOST_W     = 16,
   parameter int          PHY_AW     = 8,
   parameter int          PHY_DW     = 8,
   parameter logic [11:0] CMD_OFS    = 12'h300,
   parameter logic [11:0] DATA_OFS   = 12'h304,
   parameter bit          KEEP_UPPER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_sel,
   input  logic              hst_wr,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [HOST_W-1:0] hst_wdata,
   output logic [HOST_W-1:0] hst_rdata,
   input  logic              busy,
   input  logic              cap_vld,
   input  logic [PHY_DW-1:0] cap_data,
   output logic              cmd_go,
   output logic [PHY_AW-1:0] go_ofs,
   output logic              go_we,
   output logic [PHY_DW-1:0] stage_data
);
   localparam int WFLAG_BIT = PHY_AW;
   localparam int CMD_USED  = PHY_AW + 2;
   localparam int PAD_CMD   = HOST_W - CMD_USED;
   localparam int PAD_DATA  = HOST_W - PHY_DW;

   logic [PHY_AW-1:0] ofs_q;
   logic              we_q;
   logic [HOST_W-1:0] data_q;
   logic [HOST_W-1:0] cap_word;
   logic              cmd_hit, data_hit;

   assign cmd_hit  = hst_sel && hst_wr && (hst_addr == CMD_OFS[ADDR_W-1:0]);
   assign data_hit = hst_sel && hst_wr && (hst_addr == DATA_OFS[ADDR_W-1:0]);
   assign cmd_go   = cmd_hit && !busy;
   assign go_ofs   = hst_wdata[PHY_AW-1:0];
   assign go_we    = hst_wdata[WFLAG_BIT];
   assign stage_data = data_q[PHY_DW-1:0];

   generate
      if (KEEP_UPPER) begin : g_keep
         assign cap_word = {data_q[HOST_W-1:PHY_DW], cap_data};
      end else begin : g_zero
         assign cap_word = {{PAD_DATA{1'b0}}, cap_data};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q  <= '0;
         we_q   <= 1'b0;
         data_q <= '0;
      end else begin
         if (cmd_go) begin
            ofs_q <= go_ofs;
            we_q  <= go_we;
         end
         if (cap_vld) begin
            data_q <= cap_word;
         end else if (data_hit && !busy) begin
            data_q <= hst_wdata;
         end
      end
   end

   always_comb begin
      if (hst_addr == CMD_OFS[ADDR_W-1:0]) begin
         hst_rdata = {{PAD_CMD{1'b0}}, busy, we_q, ofs_q};
      end else if (hst_addr == DATA_OFS[ADDR_W-1:0]) begin
         hst_rdata = data_q;
      end else begin
         hst_rdata = '0;
      end
   end
endmodule

// File: rtl/phyb_xact_fsm.sv
module phyb_xact_fsm
   import phyb_pkg::*;
#(
   parameter int PHY_AW = 8,
   parameter int PHY_DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_go,
   input  logic [PHY_AW-1:0] go_ofs,
   input  logic              go_we,
   input  logic [PHY_DW-1:0] stage_data,
   output logic              busy,
   output logic              cap_vld,
   output logic [PHY_DW-1:0] cap_data,
   output logic              phy_req,
   output logic              phy_we,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [PHY_DW-1:0] phy_wdata,
   input  logic              phy_ack,
   input  logic [PHY_DW-1:0] phy_rdata
);
   xact_state_t       state_q, state_d;
   logic              we_q;
   logic [PHY_AW-1:0] addr_q;
   logic [PHY_DW-1:0] wdata_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         XS_IDLE: if (cmd_go)  state_d = XS_WAIT;
         XS_WAIT: if (phy_ack) state_d = XS_IDLE;
         default: state_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == XS_IDLE && cmd_go) begin
            we_q    <= go_we;
            addr_q  <= go_ofs;
            wdata_q <= stage_data;
         end
      end
   end

   assign busy      = (state_q == XS_WAIT);
   assign phy_req   = busy;
   assign phy_we    = we_q;
   assign phy_addr  = addr_q;
   assign phy_wdata = wdata_q;
   assign cap_vld   = busy && phy_ack && !we_q;
   assign cap_data  = phy_rdata;
endmodule

// File: rtl/phy_cmd_bridge.sv
module phy_cmd_bridge #(
   parameter int          ADDR_W     = 12,
   parameter int          HOST_W     = 16,
   parameter int          PHY_AW     = 8,
   parameter int          PHY_DW     = 8,
   parameter logic [11:0] CMD_OFS    = 12'h300,
   parameter logic [11:0] DATA_OFS   = 12'h304,
   parameter bit          KEEP_UPPER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_sel,
   input  logic              hst_wr,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [HOST_W-1:0] hst_wdata,
   output logic [HOST_W-1:0] hst_rdata,
   output logic              phy_req,
   output logic              phy_we,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [PHY_DW-1:0] phy_wdata,
   input  logic              phy_ack,
   input  logic [PHY_DW-1:0] phy_rdata
);
   generate
      if (HOST_W <= PHY_AW + 2) begin : g_bad_cmd
         $error("HOST_W must exceed PHY_AW + 2");
      end
      if (HOST_W <= PHY_DW) begin : g_bad_data
         $error("HOST_W must exceed PHY_DW");
      end
      if (ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W is limited to the 12-bit offset parameters");
      end
      if (CMD_OFS == DATA_OFS) begin : g_bad_ofs
         $error("command and data offsets must differ");
      end
   endgenerate

   logic              busy, cap_vld, cmd_go, go_we;
   logic [PHY_DW-1:0] cap_data, stage_data;
   logic [PHY_AW-1:0] go_ofs;

   phyb_host_regs #(
      .ADDR_W(ADDR_W), .HOST_W(HOST_W), .PHY_AW(PHY_AW), .PHY_DW(PHY_DW),
      .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS), .KEEP_UPPER(KEEP_UPPER)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .busy(busy), .cap_vld(cap_vld), .cap_data(cap_data),
      .cmd_go(cmd_go), .go_ofs(go_ofs), .go_we(go_we),
      .stage_data(stage_data)
   );

   phyb_xact_fsm #(
      .PHY_AW(PHY_AW), .PHY_DW(PHY_DW)
   ) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .cmd_go(cmd_go), .go_ofs(go_ofs), .go_we(go_we),
      .stage_data(stage_data),
      .busy(busy), .cap_vld(cap_vld), .cap_data(cap_data),
      .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
      .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
   );
endmodule

// File: rtl/phyb_checker.sv
module phyb_checker #(
   parameter int          ADDR_W   = 12,
   parameter int          HOST_W   = 16,
   parameter int          PHY_AW   = 8,
   parameter int          PHY_DW   = 8,
   parameter logic [11:0] CMD_OFS  = 12'h300
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hst_sel,
   input logic              hst_wr,
   input logic [ADDR_W-1:0] hst_addr,
   input logic [HOST_W-1:0] hst_wdata,
   input logic              phy_req,
   input logic              phy_we,
   input logic [PHY_AW-1:0] phy_addr,
   input logic [PHY_DW-1:0] phy_wdata,
   input logic              phy_ack
);
   logic cmd_wr;
   assign cmd_wr = hst_sel && hst_wr && (hst_addr == CMD_OFS[ADDR_W-1:0]);

   AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!phy_req && cmd_wr) |=> (phy_req && phy_addr == $past(hst_wdata[PHY_AW-1:0])
                                && phy_we == $past(hst_wdata[PHY_AW]))); // R2
   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && !phy_ack) |=> phy_req); // R4
   AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && !phy_ack) |=> ($stable(phy_addr) && $stable(phy_we)
                                 && $stable(phy_wdata))); // R4
   AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && phy_ack) |=> !phy_req); // R4
   AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && !phy_ack && cmd_wr) |=> $stable(phy_addr)); // R7
endmodule

bind phy_cmd_bridge phyb_checker #(
   .ADDR_W(ADDR_W), .HOST_W(HOST_W), .PHY_AW(PHY_AW), .PHY_DW(PHY_DW),
   .CMD_OFS(CMD_OFS)
) i_chk (
   .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
   .hst_addr(hst_addr), .hst_wdata(hst_wdata), .phy_req(phy_req),
   .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
   .phy_ack(phy_ack)
);

// File: tb/test_phy_cmd_bridge.sv
`timescale 1ns/1ps
module test_phy_cmd_bridge;
   localparam int PERIOD = 10;
   localparam logic [11:0] CMD  = 12'h300;
   localparam logic [11:0] DATA = 12'h304;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_sel = 1'b0, hst_wr = 1'b0;
   logic [11:0] hst_addr = '0;
   logic [15:0] hst_wdata = '0;
   logic [15:0] hst_rdata;
   logic        phy_req, phy_we;
   logic [7:0]  phy_addr, phy_wdata;
   logic        phy_ack = 1'b0;
   logic [7:0]  phy_rdata = '0;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int cnt = 0;
   int req_starts = 0;
   logic [7:0] mem [256];

   always #(PERIOD/2) clk = ~clk;

   phy_cmd_bridge i_phy_cmd_bridge (
      .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
      .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
   );

   // PHY register file model with a programmable answer delay
   logic req_d = 1'b0;
   always @(posedge clk) begin
      req_d <= phy_req;
      if (phy_req && !req_d) req_starts <= req_starts + 1;
      if (phy_req && !phy_ack) begin
         if (cnt >= lat) begin
            phy_ack   <= 1'b1;
            phy_rdata <= mem[phy_addr];
            if (phy_we) mem[phy_addr] <= phy_wdata;
            cnt <= 0;
         end else begin
            cnt <= cnt + 1;
         end
      end else begin
         phy_ack <= 1'b0;
      end
   end

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 5) & 8'hFF);
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
      @(negedge clk);
      hst_sel = 1'b0; hst_wr = 1'b0;
   endtask

   task automatic host_rd(input logic [11:0] a, output logic [15:0] d);
      hst_addr = a;
      #1;
      d = hst_rdata;
   endtask

   // runs one transaction and checks the command view and busy length
   task automatic xact(input logic we, input logic [7:0] ofs, input int l, input bit chk_len);
      logic [15:0] v;
      int n;
      lat = l;
      host_wr(CMD, {7'b0, we, ofs});
      host_rd(CMD, v);
      check("R9 command view while busy", v, {6'b0, 1'b1, we, ofs});
      check("R2 request fields", {5'b0, phy_req, phy_we, 1'b0, phy_addr}, {5'b0, 1'b1, we, 1'b0, ofs});
      n = 1;
      while (phy_req && n < 100) begin
         @(negedge clk);
         if (phy_req) n++;
      end
      if (chk_len) check("R4 busy length", 16'(n), 16'(l + 2));
      check("R4 request dropped", {15'b0, phy_req}, 16'h0);
   endtask

   initial begin
      #(PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int s0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      host_rd(CMD, v);  check("R1 command reg after reset", v, 16'h0000);
      host_rd(DATA, v); check("R1 data reg after reset", v, 16'h0000);
      check("R1 no request", {15'b0, phy_req}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      host_wr(DATA, 16'hA55A);
      host_rd(DATA, v); check("R10 data readback", v, 16'hA55A);

      // write sweep
      for (int a = 0; a < 256; a++) begin
         host_wr(DATA, {8'(a), pat(a)});
         lat = a % 4;
         host_wr(CMD, {7'b0, 1'b1, 8'(a)});
         check("R3 write data on port", {8'h0, phy_wdata}, {8'h0, pat(a)});
         while (phy_req) @(negedge clk);
         host_rd(DATA, v); check("R6 data reg kept after write", v, {8'(a), pat(a)});
      end
      for (int a = 0; a < 256; a++) begin
         checks++;
         if (mem[a] !== pat(a)) begin
            errors++;
            $display("FAIL R3 stored byte at %0d actual=%h expected=%h", a, mem[a], pat(a));
         end
      end

      // read sweep
      for (int a = 0; a < 256; a++) begin
         host_wr(DATA, 16'hFFFF);
         xact(1'b0, 8'(a), a % 4, 1'b1);
         host_rd(DATA, v); check("R5 read capture", v, {8'h00, pat(a)});
      end

      // accesses during busy
      host_wr(DATA, 16'h1234);
      s0 = req_starts;
      lat = 8;
      host_wr(CMD, {8'h00, 8'h40});
      host_wr(CMD, {8'h01, 8'h77});
      host_wr(DATA, 16'hBEEF);
      host_rd(CMD, v); check("R7 command unchanged while busy", v, {6'b0, 1'b1, 1'b0, 8'h40});
      host_rd(DATA, v); check("R8 data unchanged while busy", v, 16'h1234);
      while (phy_req) @(negedge clk);
      repeat (4) @(negedge clk);
      check("R7 single transaction", 16'(req_starts - s0), 16'd1);
      host_rd(DATA, v); check("R5 capture after busy writes", v, {8'h00, pat(8'h40)});
      check("R7 target byte untouched", {8'h0, mem[8'h77]}, {8'h0, pat(8'h77)});
      host_rd(CMD, v); check("R9 command view idle", v, {6'b0, 1'b0, 1'b0, 8'h40});

      // unmapped offsets
      host_wr(DATA, 16'h5AA5);
      host_wr(12'h302, 16'hFFFF);
      host_wr(12'h308, 16'h01FF);
      host_rd(12'h302, v); check("R11 unmapped read 0x302", v, 16'h0000);
      host_rd(12'h000, v); check("R11 unmapped read 0x000", v, 16'h0000);
      host_rd(DATA, v); check("R11 data reg untouched", v, 16'h5AA5);
      host_rd(CMD, v); check("R11 command reg untouched", v, {8'h00, 8'h40});
      check("R11 no request", {15'b0, phy_req}, 16'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule